// File: doc/BRIEF.md
# DMA Channel Request and Address Sequencer

This block handles the request side of one DMA channel. A control byte chooses what starts a transfer: a request that is always present, or that pauses between transfers, the external request line, or a compare-match pulse from one of four timer channels. The block turns the chosen event into a request to a bus master. It also steps a memory address register each time the master acknowledges a transfer. A master-enable bit in the same byte gates every request.

The `block_mode` input sets how the three source-select bits are read. Normal mode gives the continuous and paused requests and both forms of the external line. Block mode gives the four timer pulses and the falling edge of the external line. Any other select code keeps the request low. A transfer completes in a cycle where both `req` and `ack` are high. The address register then holds, or moves by one for a byte transfer or by two for a word transfer, in the direction the control byte gives. A separate port loads the address register directly.

Top module: `dma_req_seq`

## Requirements
- R1: After reset the control byte reads 0x00, `req` is 0, `addr` is 0 and `blk_is_src` is 0.
- R2: While control bit 7 (enable) is 0, `req` stays 0 whatever the triggers do.
- R3: With enable set, normal mode and select 000, `req` is high in every cycle, including cycles after an acknowledge.
- R4: With enable set, normal mode and select 010, `req` is high except in the cycle that follows a completed transfer, where it is 0.
- R5: Select 110 in either mode latches a falling edge of the active-low `dreq_n`. `req` rises three clock edges after `dreq_n` falls and stays high until a completed transfer clears it.
- R6: With enable set, normal mode and select 111, `req` is high while `dreq_n` is low, after two clock edges of synchronization.
- R7: In block mode, selects 000, 001, 010 and 011 latch a pulse on `tmr_cm[0]`, `tmr_cm[1]`, `tmr_cm[2]` and `tmr_cm[3]`. `req` rises one edge after the pulse and drops after a completed transfer. Pulses on any other channel have no effect.
- R8: The codes normal 001, 011, 100 and 101, and block 100, 101 and 111, never raise `req`.
- R9: When control bit 4 (step enable) is 0, a completed transfer leaves `addr` unchanged, whatever the direction bit holds.
- R10: When bit 4 is 1, a completed transfer changes `addr` by 1 if `word_size`=0 or by 2 if `word_size`=1. It adds when bit 5 is 0 and subtracts when bit 5 is 1, modulo 2^24.
- R11: `blk_is_src` follows control bit 3, where 1 means the source is the block area and 0 means the destination is.
- R12: `addr_we` loads `addr_wdata` into `addr` at the next edge, taking priority over a step in the same cycle.
- R13: Every bit of the control byte, including reserved bit 6, can be written and read back on `cfg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte current value |
| block_mode | input | 1 | 1 selects block mode decoding of the source field |
| word_size | input | 1 | 1 selects word transfers (step of 2) |
| addr_we | input | 1 | Address register load strobe |
| addr_wdata | input | 24 | Address register load value |
| addr | output | 24 | Memory address register |
| tmr_cm | input | 4 | One-cycle compare-match pulses, one bit per timer channel |
| dreq_n | input | 1 | Asynchronous active-low external request |
| req | output | 1 | Transfer request to the bus master |
| ack | input | 1 | Transfer acknowledge from the bus master |
| blk_is_src | output | 1 | Block-area select flag |

## Verification
The hardest case to reach is the cycle after an acknowledge while the external line is still low. Here the level source must keep requesting, the edge source must drop its latched request, and the paused auto-request must go quiet for exactly one cycle. The stimulus sweeps every mode and select code with enable both on and off. For each one it pulses each timer channel, pulls `dreq_n` low, and acknowledges while the line is still held low. It checks `req` at the synchronizer latency and again in each cycle after the acknowledge.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA request sequencer.
// Assumes the control byte layout is fixed at eight bits.
package dma_seq_pkg;

    // Kind of activation source that a select code resolves to
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_BURST,
        SRC_STEAL,
        SRC_DREQ_EDGE,
        SRC_DREQ_LEVEL,
        SRC_TIMER
    } src_kind_e;

    // Control byte, msb first
    typedef struct packed {
        logic       en;
        logic       rsvd;
        logic       dir_dn;
        logic       step_en;
        logic       blk_src;
        logic [2:0] sel;
    } ctrl_t;

endpackage

// File: rtl/dma_src_decode.sv
// Source decoder: maps the select field and mode flag to a source kind
// and a timer channel index.
// Assumes four or fewer timer channels, indexed by the low select bits.
module dma_src_decode
    import dma_seq_pkg::*;
#(
    parameter int TMR_CH = 4,
    localparam int TIDX_W = (TMR_CH > 1) ? $clog2(TMR_CH) : 1
) (
    input  logic [2:0]        sel,
    input  logic              block_mode,
    output src_kind_e         kind,
    output logic [TIDX_W-1:0] tmr_idx
);

    // Timer index comes straight from the low select bits
    assign tmr_idx = sel[TIDX_W-1:0];

    // Resolve the source kind for the current mode
    always_comb begin
        kind = SRC_NONE;
        if (!block_mode) begin
            case (sel)
                3'b000:  kind = SRC_BURST;
                3'b010:  kind = SRC_STEAL;
                3'b110:  kind = SRC_DREQ_EDGE;
                3'b111:  kind = SRC_DREQ_LEVEL;
                default: kind = SRC_NONE;
            endcase
        end else begin
            if (sel == 3'b110)
                kind = SRC_DREQ_EDGE;
            else if (!sel[2] && (int'(sel[1:0]) < TMR_CH))
                kind = SRC_TIMER;
            else
                kind = SRC_NONE;
        end
    end

endmodule

// File: rtl/dma_dreq_sync.sv
// External request synchronizer: a chain of flops brings the active-low
// pin into the clock domain, and one more register detects its fall.
// Assumes dreq_n is asynchronous and idles high.
module dma_dreq_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_n,
    output logic dreq_low,
    output logic dreq_fall
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the raw pin
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= dreq_n;
            end
        end else begin : g_next
            // Later stages pass the value along
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    // Keep the previous synchronized value for the edge detector
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain[SYNC_STAGES-1];
    end

    assign dreq_low  = ~chain[SYNC_STAGES-1];
    assign dreq_fall = last_q & ~chain[SYNC_STAGES-1];

endmodule

// File: rtl/dma_req_ctrl.sv
// Request generator: turns the decoded source into the req output.
// Edge-type events are held pending until a completed transfer.
// A paused auto-request drops req for one cycle after each transfer.
// Assumes timer pulses are already synchronous to clk.
module dma_req_ctrl
    import dma_seq_pkg::*;
#(
    parameter int TMR_CH = 4,
    localparam int TIDX_W = (TMR_CH > 1) ? $clog2(TMR_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  src_kind_e         kind,
    input  logic [TIDX_W-1:0] tmr_idx,
    input  logic [TMR_CH-1:0] tmr_cm,
    input  logic              dreq_low,
    input  logic              dreq_fall,
    input  logic              ack,
    output logic              req
);

    logic pend_q;
    logic hold_q;
    logic trig;
    logic edge_src;
    logic done;

    assign edge_src = (kind == SRC_DREQ_EDGE) || (kind == SRC_TIMER);
    assign trig     = ((kind == SRC_DREQ_EDGE) && dreq_fall) ||
                      ((kind == SRC_TIMER) && tmr_cm[tmr_idx]);
    assign done     = ack && req;

    // Latch edge and timer events until a transfer consumes them
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (!en || !edge_src) pend_q <= 1'b0;
        else                       pend_q <= (pend_q && !done) || trig;
    end

    // Pause the cycle-steal request for one cycle after each transfer
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= done && (kind == SRC_STEAL);
    end

    // Combine the source kind with its state to form the request
    always_comb begin
        req = 1'b0;
        if (en) begin
            case (kind)
                SRC_BURST:      req = 1'b1;
                SRC_STEAL:      req = !hold_q;
                SRC_DREQ_LEVEL: req = dreq_low;
                SRC_DREQ_EDGE:  req = pend_q;
                SRC_TIMER:      req = pend_q;
                default:        req = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dma_addr_step.sv
// Address register: loads through its own port, or holds or steps by
// one or two on each completed transfer. Wraps modulo 2^AW.
// Assumes load takes priority over a step in the same cycle.
module dma_addr_step #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          done,
    input  logic          step_en,
    input  logic          dir_dn,
    input  logic          word,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] delta;

    assign delta = word ? AW'(2) : AW'(1);

    // Load, step or hold the address
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (done && step_en)
            addr <= dir_dn ? (addr - delta) : (addr + delta);
    end

endmodule

// File: rtl/dma_req_seq.sv
// DMA channel request and address sequencer (top). Holds the control
// byte, decodes the activation source, synchronizes the external request,
// raises req and steps the address register on each req/ack transfer.
// Assumes a transfer completes in any cycle where req and ack are both high.
module dma_req_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int TMR_CH      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int TIDX_W = (TMR_CH > 1) ? $clog2(TMR_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              block_mode,
    input  logic              word_size,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] addr,
    input  logic [TMR_CH-1:0] tmr_cm,
    input  logic              dreq_n,
    output logic              req,
    input  logic              ack,
    output logic              blk_is_src
);

    ctrl_t             ctrl_q;
    src_kind_e         kind;
    logic [TIDX_W-1:0] tmr_idx;
    logic              dreq_low;
    logic              dreq_fall;
    logic              xfer_done;

    // Control byte register
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (cfg_we) ctrl_q <= ctrl_t'(cfg_wdata);
    end

    assign cfg_rdata  = ctrl_q;
    assign blk_is_src = ctrl_q.blk_src;
    assign xfer_done  = req && ack;

    dma_src_decode #(.TMR_CH(TMR_CH)) u_decode (
        .sel        (ctrl_q.sel),
        .block_mode (block_mode),
        .kind       (kind),
        .tmr_idx    (tmr_idx)
    );

    dma_dreq_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq_n    (dreq_n),
        .dreq_low  (dreq_low),
        .dreq_fall (dreq_fall)
    );

    dma_req_ctrl #(.TMR_CH(TMR_CH)) u_reqc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_q.en),
        .kind      (kind),
        .tmr_idx   (tmr_idx),
        .tmr_cm    (tmr_cm),
        .dreq_low  (dreq_low),
        .dreq_fall (dreq_fall),
        .ack       (ack),
        .req       (req)
    );

    dma_addr_step #(.AW(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_we),
        .load_val (addr_wdata),
        .done     (xfer_done),
        .step_en  (ctrl_q.step_en),
        .dir_dn   (ctrl_q.dir_dn),
        .word     (word_size),
        .addr     (addr)
    );

endmodule

// File: rtl/dma_req_seq_chk.sv
// Assertion checker for dma_req_seq, bound to the top module.
// Observes ports only.
module dma_req_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_rdata,
    input logic              block_mode,
    input logic              word_size,
    input logic              addr_we,
    input logic [ADDR_W-1:0] addr_wdata,
    input logic [ADDR_W-1:0] addr,
    input logic              ack,
    input logic              req
);

    logic [ADDR_W-1:0] step_amt;
    logic              bad_code;
    logic [2:0]        s;

    assign s        = cfg_rdata[2:0];
    assign step_amt = word_size ? ADDR_W'(2) : ADDR_W'(1);
    assign bad_code = (!block_mode && (s == 3'd1 || s == 3'd3 || s == 3'd4 || s == 3'd5)) ||
                      ( block_mode && (s == 3'd4 || s == 3'd5 || s == 3'd7));

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[7] |-> !req);

    p_burst_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] && !block_mode && s == 3'b000) |-> req);

    p_steal_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && cfg_rdata[7] && !block_mode && s == 3'b010 && !cfg_we) |=> !req);

    p_bad_code_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |-> !req);

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !cfg_rdata[4] && !addr_we) |=> $stable(addr));

    p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && cfg_rdata[4] && !addr_we) |=>
        (addr == ($past(cfg_rdata[5]) ? ($past(addr) - $past(step_amt))
                                      : ($past(addr) + $past(step_amt)))));

    p_addr_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> (addr == $past(addr_wdata)));

endmodule

bind dma_req_seq dma_req_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .block_mode (block_mode),
    .word_size  (word_size),
    .addr_we    (addr_we),
    .addr_wdata (addr_wdata),
    .addr       (addr),
    .ack        (ack),
    .req        (req)
);

// File: tb/dma_req_seq_bench.sv
`timescale 1ns/1ps
// Bench for dma_req_seq: sweeps every mode, select code and enable value
// against timer and external-request stimulus, then sweeps the address
// stepping options. All expected values are computed here.
module dma_req_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        block_mode = 1'b0;
    logic        word_size = 1'b0;
    logic        addr_we = 1'b0;
    logic [23:0] addr_wdata = 24'h0;
    logic [23:0] addr;
    logic [3:0]  tmr_cm = 4'h0;
    logic        dreq_n = 1'b1;
    logic        req;
    logic        ack = 1'b0;
    logic        blk_is_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_req_seq u_dma_req_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .block_mode(block_mode), .word_size(word_size),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .addr(addr),
        .tmr_cm(tmr_cm), .dreq_n(dreq_n), .req(req), .ack(ack),
        .blk_is_src(blk_is_src)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        cfg_wdata = v;
        cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    // Sweep one mode/select/enable combination
    task automatic sweep_src(input bit m, input logic [2:0] sel, input bit en);
        bit burst, steal, edg, lvl, tmr, bad;
        logic exp;
        string tag;
        burst = !m && sel == 3'd0;
        steal = !m && sel == 3'd2;
        edg   = sel == 3'd6;
        lvl   = !m && sel == 3'd7;
        tmr   = m && !sel[2];
        bad   = !(burst || steal || edg || lvl || tmr);
        if (!en)        tag = "R2";
        else if (bad)   tag = "R8";
        else if (burst) tag = "R3";
        else if (steal) tag = "R4";
        else if (tmr)   tag = "R7";
        else if (lvl)   tag = "R6";
        else            tag = "R5";
        block_mode = m;
        wr_ctrl({en, 4'b0000, sel});
        chk(tag, req, en && (burst || steal));
        for (int ch = 0; ch < 4; ch++) begin
            tmr_cm = 4'(1 << ch);
            step(1);
            tmr_cm = 4'h0;
            exp = en && (burst || steal || (tmr && int'(sel[1:0]) == ch));
            chk(tag, req, exp);
            if (en && tmr && int'(sel[1:0]) == ch) begin
                ack = 1'b1;
                step(1);
                ack = 1'b0;
                chk("R7", req, 1'b0);
            end
        end
        dreq_n = 1'b0;
        step(2);
        chk(tag, req, en && (burst || steal || lvl));
        step(1);
        chk(tag, req, en && (burst || steal || lvl || edg));
        ack = 1'b1;
        step(1);
        ack = 1'b0;
        chk(tag, req, en && (burst || lvl));
        step(1);
        chk(tag, req, en && (burst || steal || lvl));
        dreq_n = 1'b1;
        step(3);
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog got=0 exp=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] ea;
        logic [23:0] starts [3];
        starts[0] = 24'h000000;
        starts[1] = 24'hFFFFFE;
        starts[2] = 24'h123456;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", cfg_rdata, 8'h00);
        chk("R1", req, 1'b0);
        chk("R1", addr, 24'h0);
        chk("R1", blk_is_src, 1'b0);

        // R13 readback including reserved bit, R11 block flag
        wr_ctrl(8'h4A);
        chk("R13", cfg_rdata, 8'h4A);
        chk("R11", blk_is_src, 1'b1);
        wr_ctrl(8'h35);
        chk("R13", cfg_rdata, 8'h35);
        chk("R11", blk_is_src, 1'b0);

        // Source sweep
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 8; s++)
                for (int e = 0; e < 2; e++)
                    sweep_src(m[0], 3'(s), e[0]);

        // Address sweep using the burst source (req always high)
        block_mode = 1'b0;
        for (int se = 0; se < 2; se++)
            for (int dn = 0; dn < 2; dn++)
                for (int w = 0; w < 2; w++)
                    for (int k = 0; k < 3; k++) begin
                        wr_ctrl({1'b1, 1'b0, dn[0], se[0], 4'b0000});
                        word_size = w[0];
                        addr_wdata = starts[k];
                        addr_we = 1'b1;
                        step(1);
                        addr_we = 1'b0;
                        chk("R12", addr, starts[k]);
                        ea = starts[k];
                        for (int t = 0; t < 3; t++) begin
                            ack = 1'b1;
                            step(1);
                            ack = 1'b0;
                            if (se != 0)
                                ea = (dn != 0) ? ea - 24'(w + 1) : ea + 24'(w + 1);
                            chk(se != 0 ? "R10" : "R9", addr, ea);
                        end
                    end

        // R12 load wins over a step in the same cycle
        wr_ctrl(8'h90);
        addr_wdata = 24'hABCDEF;
        addr_we = 1'b1;
        ack = 1'b1;
        step(1);
        addr_we = 1'b0;
        ack = 1'b0;
        chk("R12", addr, 24'hABCDEF);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule